// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits between a CPU's I/O port accesses and the configuration registers of the devices on a local bus. The CPU first writes a packed location (enable, bus, device, function, dword index) to the address port. A later read or write to the data port turns into exactly one aligned 32-bit configuration access to the location held in that register.

The CPU side has two valid/ready channels. A request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Only one access is in flight at a time, so `cpu_req_ready` stays low from acceptance until the response has been taken. The response is taken on a cycle where `cpu_rsp_valid` and `cpu_rsp_ready` are both high. While `cpu_rsp_ready` is low, the response and its data are held unchanged.

The target side has no handshake. The block issues a one-cycle request, and the decoded location is shown on the target pins at all times. A read waits for the target's `tgt_rvalid` strobe. If the enable bit is clear, or if no target claims the location, the access never reaches the target side: a read returns all ones and a write is discarded.

Top module: `pcicfg_bridge`

## Requirements
- R1: After reset the address register holds 0, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `tgt_req` are 0.
- R2: A write to port 0xCF8 with `cpu_req_be` = 4'hF stores the data with bits 30:24 and 1:0 cleared. A read of 0xCF8 returns the stored value.
- R3: A write to 0xCF8 with any `cpu_req_be` other than 4'hF leaves the address register unchanged.
- R4: The stored address is decoded and shown on the target pins as follows: bit 31 enable, bits 23:16 to `tgt_bus`, bits 15:11 to `tgt_dev`, bits 10:8 to `tgt_fn`, and bits 7:2 to `tgt_reg`.
- R5: A read of port 0xCFC, with enable set and `tgt_hit` high, sends one single-cycle `tgt_req` with `tgt_we`=0. The response is held back until `tgt_rvalid` arrives, and then returns `tgt_rdata`.
- R6: A write to 0xCFC, with enable set and `tgt_hit` high, sends one single-cycle `tgt_req` with `tgt_we`=1 and `tgt_wdata` equal to the CPU data. Its response data is 0.
- R7: With the enable bit clear, a read of 0xCFC returns 32'hFFFFFFFF and a write to it produces no `tgt_req`.
- R8: With `tgt_hit` low, a read of 0xCFC returns 32'hFFFFFFFF and a write to it produces no `tgt_req`.
- R9: Requests are taken only while `cpu_req_ready` is high, and `cpu_req_ready` is never high together with `cpu_rsp_valid`. A response that is not taken keeps its valid and its data stable.
- R10: An access to any other port completes without a `tgt_req`. A read of such a port returns 32'hFFFFFFFF, and a write to it changes nothing.
- R11: A `tgt_rvalid` pulse that arrives while no read is waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_port | input | 16 | I/O port number |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_be | input | 4 | Byte enables (full dword = 4'hF) |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | CPU takes the response |
| cpu_rsp_rdata | output | 32 | Read data (0 for writes) |
| tgt_req | output | 1 | One-cycle configuration request |
| tgt_we | output | 1 | Request is a write |
| tgt_bus | output | 8 | Decoded bus number |
| tgt_dev | output | 5 | Decoded device number |
| tgt_fn | output | 3 | Decoded function number |
| tgt_reg | output | 6 | Decoded dword index |
| tgt_wdata | output | 32 | Configuration write data |
| tgt_hit | input | 1 | A target claims the shown location |
| tgt_rvalid | input | 1 | Read data strobe |
| tgt_rdata | input | 32 | Read data |

## Verification
The data port is tried in three situations: with a claimed location, with the enable bit cleared, and with a device number that no target claims. Comparing these separates a real target access from the all-ones answer, and separates gating by the enable bit from gating by the claim. The target model builds its read data from the location it receives, so a wrong field slice shows up as a wrong value. The address port is tried with full, partial and all-ones writes, which checks the reserved-bit masking and the byte-enable filter. A stall pattern on `cpu_rsp_ready` and stray `tgt_rvalid` pulses check that responses are held stable and that unrequested read data is ignored.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 6;
  localparam int DW    = 32;
  localparam logic [DW-1:0] ADDR_KEEP = 32'h80FF_FFFC;
  localparam logic [DW-1:0] ALL_ONES  = '1;

  typedef struct packed {
    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] dw;
  } cfg_loc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} st_t;
  typedef enum logic [1:0] {K_ADDR, K_DATA, K_OTHER} kind_t;

  function automatic cfg_loc_t unpack_addr(input logic [DW-1:0] a);
    cfg_loc_t l;
    l.en  = a[31];
    l.bus = a[23:16];
    l.dev = a[15:11];
    l.fn  = a[10:8];
    l.dw  = a[7:2];
    return l;
  endfunction
endpackage

// File: rtl/pcicfg_addr_reg.sv
module pcicfg_addr_reg
  import pcicfg_pkg::*;
#(
  parameter logic [DW-1:0] KEEP = ADDR_KEEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output cfg_loc_t      loc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & KEEP;
  end

  assign loc = unpack_addr(q);
endmodule

// File: rtl/pcicfg_port_dec.sv
module pcicfg_port_dec
  import pcicfg_pkg::*;
#(
  parameter int              PORT_W    = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
  input  logic [PORT_W-1:0] port,
  output kind_t             kind
);
  always_comb begin
    if (port == ADDR_PORT)      kind = K_ADDR;
    else if (port == DATA_PORT) kind = K_DATA;
    else                        kind = K_OTHER;
  end
endmodule

// File: rtl/pcicfg_ctrl.sv
module pcicfg_ctrl
  import pcicfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  kind_t         req_kind,
  input  logic          req_write,
  input  logic          req_full,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] addr_q,
  input  logic          loc_en,
  input  logic          tgt_hit,
  input  logic          tgt_rvalid,
  input  logic [DW-1:0] tgt_rdata,
  input  logic          rsp_ready,
  output logic          req_ready,
  output logic          addr_wr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          tgt_req,
  output logic          tgt_we,
  output logic [DW-1:0] tgt_wdata
);
  st_t  st_q;
  logic accept;
  logic claim;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign claim     = loc_en & tgt_hit;
  assign addr_wr   = accept && (req_kind == K_ADDR) && req_write && req_full;
  assign rsp_valid = (st_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_rdata <= '0;
      tgt_req   <= 1'b0;
      tgt_we    <= 1'b0;
      tgt_wdata <= '0;
    end else begin
      tgt_req <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (req_kind == K_ADDR) begin
            rsp_rdata <= req_write ? '0 : addr_q;
            st_q      <= ST_RESP;
          end else if (req_kind == K_DATA && claim) begin
            tgt_req   <= 1'b1;
            tgt_we    <= req_write;
            tgt_wdata <= req_write ? req_wdata : '0;
            rsp_rdata <= '0;
            st_q      <= req_write ? ST_RESP : ST_WAIT;
          end else begin
            rsp_rdata <= req_write ? '0 : ALL_ONES;
            st_q      <= ST_RESP;
          end
        end
        ST_WAIT: if (tgt_rvalid) begin
          rsp_rdata <= tgt_rdata;
          st_q      <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcicfg_bridge.sv
module pcicfg_bridge
  import pcicfg_pkg::*;
#(
  parameter int                PORT_W    = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [PORT_W-1:0] cpu_req_port,
  input  logic              cpu_req_write,
  input  logic [3:0]        cpu_req_be,
  input  logic [31:0]       cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [31:0]       cpu_rsp_rdata,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [7:0]        tgt_bus,
  output logic [4:0]        tgt_dev,
  output logic [2:0]        tgt_fn,
  output logic [5:0]        tgt_reg,
  output logic [31:0]       tgt_wdata,
  input  logic              tgt_hit,
  input  logic              tgt_rvalid,
  input  logic [31:0]       tgt_rdata
);
  kind_t         kind;
  logic          addr_wr;
  logic [DW-1:0] addr_q;
  cfg_loc_t      loc;

  pcicfg_port_dec #(
    .PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .port(cpu_req_port),
    .kind(kind)
  );

  pcicfg_addr_reg #(.KEEP(ADDR_KEEP)) u_areg (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(addr_wr),
    .wdata(cpu_req_wdata),
    .q    (addr_q),
    .loc  (loc)
  );

  pcicfg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cpu_req_valid),
    .req_kind  (kind),
    .req_write (cpu_req_write),
    .req_full  (cpu_req_be == 4'hF),
    .req_wdata (cpu_req_wdata),
    .addr_q    (addr_q),
    .loc_en    (loc.en),
    .tgt_hit   (tgt_hit),
    .tgt_rvalid(tgt_rvalid),
    .tgt_rdata (tgt_rdata),
    .rsp_ready (cpu_rsp_ready),
    .req_ready (cpu_req_ready),
    .addr_wr   (addr_wr),
    .rsp_valid (cpu_rsp_valid),
    .rsp_rdata (cpu_rsp_rdata),
    .tgt_req   (tgt_req),
    .tgt_we    (tgt_we),
    .tgt_wdata (tgt_wdata)
  );

  assign tgt_bus = loc.bus;
  assign tgt_dev = loc.dev;
  assign tgt_fn  = loc.fn;
  assign tgt_reg = loc.dw;
endmodule

// File: rtl/pcicfg_bridge_chk.sv
module pcicfg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req_ready,
  input logic        cpu_rsp_valid,
  input logic        cpu_rsp_ready,
  input logic [31:0] cpu_rsp_rdata,
  input logic        tgt_req,
  input logic [7:0]  tgt_bus,
  input logic [4:0]  tgt_dev,
  input logic [2:0]  tgt_fn,
  input logic [5:0]  tgt_reg,
  input logic [31:0] addr_q
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata));
  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req_ready && cpu_rsp_valid));
  // R5
  tgt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |=> !tgt_req);
  // R7
  tgt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> addr_q[31]);
  // R2
  addr_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & 32'h7F00_0003) == 32'h0);
  // R4
  loc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req_ready |=> $stable({tgt_bus, tgt_dev, tgt_fn, tgt_reg}));
endmodule

bind pcicfg_bridge pcicfg_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .cpu_rsp_ready(cpu_rsp_ready),
  .cpu_rsp_rdata(cpu_rsp_rdata),
  .tgt_req      (tgt_req),
  .tgt_bus      (tgt_bus),
  .tgt_dev      (tgt_dev),
  .tgt_fn       (tgt_fn),
  .tgt_reg      (tgt_reg),
  .addr_q       (addr_q)
);

// File: tb/test_pcicfg_bridge.sv
`timescale 1ns/1ps
module test_pcicfg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [15:0] cpu_req_port = '0;
  logic        cpu_req_write = 1'b0;
  logic [3:0]  cpu_req_be = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b0;
  logic [31:0] cpu_rsp_rdata;
  logic        tgt_req, tgt_we;
  logic [7:0]  tgt_bus;
  logic [4:0]  tgt_dev;
  logic [2:0]  tgt_fn;
  logic [5:0]  tgt_reg;
  logic [31:0] tgt_wdata;
  logic        tgt_hit;
  logic        tgt_rvalid = 1'b0;
  logic [31:0] tgt_rdata = '0;

  always #4 clk = ~clk;

  pcicfg_bridge i_pcicfg_bridge (.*);

  assign tgt_hit = (tgt_dev != 5'd31);

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          wr_cnt = 0, rd_cnt = 0;
  logic [31:0] last_wdata = '0;
  logic        stray_go = 1'b0;
  logic        done = 1'b0;

  function automatic logic [31:0] tgt_model(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f, input logic [5:0] r);
    return {8'hA5, b, d, f, r, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] port, input bit wr, input logic [3:0] be,
                     input logic [31:0] wd, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_port = port; cpu_req_write = wr;
    cpu_req_be = be; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor / scoreboard with response stall pattern (R9)
  initial begin
    int cyc = 0;
    bit hold_pend = 0;
    logic [31:0] hold_val = '0;
    forever begin
      @(negedge clk);
      if (hold_pend)
        chk(cpu_rsp_valid && cpu_rsp_rdata == hold_val, "R9 held response", cpu_rsp_rdata, hold_val);
      hold_pend = 0;
      cyc++;
      cpu_rsp_ready = (cyc % 3 != 0);
      if (cpu_rsp_valid && rst_n) begin
        if (cpu_rsp_ready) begin
          if (exp_q.size() == 0) chk(0, "R9 unexpected response", cpu_rsp_rdata, 32'h0);
          else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cpu_rsp_rdata == e, t, cpu_rsp_rdata, e);
          end
        end else begin
          hold_pend = 1;
          hold_val = cpu_rsp_rdata;
        end
      end
    end
  end

  // Target model: read data two cycles after the request
  initial begin
    bit pend = 0;
    int wt = 0;
    logic [31:0] pdata = '0;
    forever begin
      @(negedge clk);
      tgt_rvalid = 1'b0;
      if (stray_go) begin
        tgt_rvalid = 1'b1; tgt_rdata = 32'h0BAD_0BAD; stray_go = 1'b0;
      end else if (pend) begin
        if (wt == 0) begin
          tgt_rvalid = 1'b1; tgt_rdata = pdata; pend = 0;
        end else wt--;
      end
      if (tgt_req) begin
        if (tgt_we) begin
          wr_cnt++; last_wdata = tgt_wdata;
        end else begin
          rd_cnt++; pend = 1; wt = 1;
          pdata = tgt_model(tgt_bus, tgt_dev, tgt_fn, tgt_reg);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready && !cpu_rsp_valid && !tgt_req, "R1 reset outputs",
        {29'b0, cpu_req_ready, cpu_rsp_valid, tgt_req}, 32'h4);
    acc(16'hCF8, 0, 4'hF, 0, 32'h0, "R1 addr reg reset");
    // R2 masking and read-back
    acc(16'hCF8, 1, 4'hF, 32'hFFFF_FFFF, 32'h0, "R2 write resp");
    acc(16'hCF8, 0, 4'hF, 0, 32'h80FF_FFFC, "R2 masked read-back");
    // R3 partial writes ignored
    acc(16'hCF8, 1, 4'h3, 32'h1234_5678, 32'h0, "R3 write resp");
    acc(16'hCF8, 1, 4'hE, 32'h0000_0000, 32'h0, "R3 write resp");
    acc(16'hCF8, 0, 4'hF, 0, 32'h80FF_FFFC, "R3 unchanged");
    // R4 field decode
    a = 32'h8000_0000 | (32'd3 << 16) | (32'd7 << 11) | (32'd2 << 8) | (32'h15 << 2);
    acc(16'hCF8, 1, 4'hF, a, 32'h0, "R4 write resp");
    chk({tgt_bus, tgt_dev, tgt_fn, tgt_reg} == {8'd3, 5'd7, 3'd2, 6'h15}, "R4 fields",
        {10'b0, tgt_bus, tgt_dev, tgt_fn, tgt_reg}, {10'b0, 8'd3, 5'd7, 3'd2, 6'h15});
    // R5 claimed read
    r0 = rd_cnt;
    acc(16'hCFC, 0, 4'hF, 0, tgt_model(8'd3, 5'd7, 3'd2, 6'h15), "R5 read data");
    chk(rd_cnt == r0 + 1, "R5 one read request", rd_cnt, r0 + 1);
    // R6 claimed write
    w0 = wr_cnt;
    acc(16'hCFC, 1, 4'hF, 32'hDEAD_BEEF, 32'h0, "R6 write resp");
    chk(wr_cnt == w0 + 1 && last_wdata == 32'hDEAD_BEEF, "R6 write request", last_wdata, 32'hDEAD_BEEF);
    // R4/R5 several locations
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b; logic [4:0] d; logic [2:0] f; logic [5:0] r;
      b = 8'(i * 37 + 1); d = 5'(i * 5 + 2); f = 3'(i + 4); r = 6'(63 - i * 9);
      acc(16'hCF8, 1, 4'hF, {1'b1, 7'h7F, b, d, f, r, 2'b11}, 32'h0, "R4 write resp");
      acc(16'hCFC, 0, 4'hF, 0, tgt_model(b, d, f, r), "R4 decoded read");
    end
    // R7 enable clear
    r0 = rd_cnt; w0 = wr_cnt;
    acc(16'hCF8, 1, 4'hF, a & 32'h7FFF_FFFF, 32'h0, "R7 write resp");
    acc(16'hCFC, 0, 4'hF, 0, 32'hFFFF_FFFF, "R7 disabled read");
    acc(16'hCFC, 1, 4'hF, 32'h1111_2222, 32'h0, "R7 disabled write resp");
    chk(rd_cnt == r0 && wr_cnt == w0, "R7 no target request", rd_cnt + wr_cnt, r0 + w0);
    // R8 no target claims
    acc(16'hCF8, 1, 4'hF, 32'h8001_F800, 32'h0, "R8 write resp");
    acc(16'hCFC, 0, 4'hF, 0, 32'hFFFF_FFFF, "R8 unclaimed read");
    acc(16'hCFC, 1, 4'hF, 32'h3333_4444, 32'h0, "R8 unclaimed write resp");
    chk(rd_cnt == r0 && wr_cnt == w0, "R8 no target request", rd_cnt + wr_cnt, r0 + w0);
    // R10 other port
    acc(16'h0080, 0, 4'hF, 0, 32'hFFFF_FFFF, "R10 other read");
    acc(16'h0CF9, 1, 4'hF, 32'h8000_0000, 32'h0, "R10 other write resp");
    acc(16'hCF8, 0, 4'hF, 0, 32'h8001_F800, "R10 addr unchanged");
    chk(rd_cnt == r0 && wr_cnt == w0, "R10 no target request", rd_cnt + wr_cnt, r0 + w0);
    // R11 stray read strobe while idle
    @(negedge clk);
    stray_go = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cpu_rsp_valid, "R11 no spurious response", {31'b0, cpu_rsp_valid}, 32'h0);
    acc(16'hCF8, 0, 4'hF, 0, 32'h8001_F800, "R11 idle strobe ignored");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule